// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a two-plane bitmapped pointer over an 8-bit indexed pixel stream. Each clock it receives the raster coordinate of the pixel being shown and that pixel's screen value. It returns the pixel that goes to the palette. Inside the cursor rectangle, every cursor pixel carries a two-bit code. The code picks the background color, the foreground color, the untouched screen pixel, or the bitwise inverse of the screen pixel. A per-bit mask limits which output bits the cursor may alter.

The rectangle is placed by a position register and a hot-spot offset; the offset is subtracted from the position to give the top-left corner. Height is 16, 32, 64 or 128 lines and width is 32 or 64 pixels. The bitmap sits in an internal line store that a host port fills with 32-bit words. A frame-start strobe advances a frame counter, and that counter gates the cursor when blinking is enabled.

The block has no bitmap fetch from external memory and no host register decode. Software-visible settings arrive as plain configuration inputs and are expected to stay steady while pixels flow.

Top module: `curs_overlay`

## Requirements
- R1: While rst is high at a rising edge, pix_out becomes 0 at that edge and the frame counter returns to 0.
- R2: pix_out is registered; the value after rising edge k+1 is computed from the pixel inputs sampled at edge k (two-edge latency). Colors and mask are taken one edge later than the pixel inputs.
- R3: Cursor code {plane0 bit, plane1 bit} selects: 00 color_bg, 01 color_fg, 10 pix_in unchanged, 11 bitwise inverse of pix_in.
- R4: Output bit i equals pix_in bit i whenever pix_mask bit i is 0. Where the mask bit is 1, it takes the cursor value for that bit.
- R5: cur_height codes 0,1,2,3 give 16, 32, 64 and 128 cursor lines.
- R6: cur_wide=1 gives a 64-pixel-wide cursor; cur_wide=0 gives a 32-pixel-wide cursor.
- R7: col = pix_x - pos_x + hot_x and row = pix_y - pos_y + hot_y, both taken as signed values. The pixel is inside the cursor when 0 <= col < width and 0 <= row < height. This holds even when the corner lies left of or above the screen origin.
- R8: Each line holds one 64-bit map per plane. The load address is {line[6:0], plane, half}, with plane 0 being the first plane; word half h fills map bits 32h+31..32h. Column c reads map bit W-1-c, where W is the width in use, so the first pixel comes from the last byte of the map.
- R9: With cur_en low, or outside the rectangle, pix_out equals pix_in.
- R10: The frame counter advances by one on each frame_start. With blink_en set, the cursor is hidden while counter bit 3 (blink_slow=0, 8 on/8 off) or bit 4 (blink_slow=1, 16 on/16 off) is 1, and shown first after reset. With blink_en clear, the counter has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_x | input | 11 | Raster column of the incoming pixel |
| pix_y | input | 11 | Raster line of the incoming pixel |
| pix_in | input | 8 | Screen pixel value |
| cur_en | input | 1 | Cursor enable |
| cur_height | input | 2 | Height code: 16/32/64/128 lines |
| cur_wide | input | 1 | 1: 64 pixels wide, 0: 32 pixels wide |
| blink_en | input | 1 | Enable frame-count blinking |
| blink_slow | input | 1 | 1: 16-frame phases, 0: 8-frame phases |
| pos_x | input | 11 | Cursor horizontal position |
| pos_y | input | 11 | Cursor vertical position |
| hot_x | input | 6 | Hot-spot column inside the cursor |
| hot_y | input | 7 | Hot-spot line inside the cursor |
| color_fg | input | 8 | Foreground color |
| color_bg | input | 8 | Background color |
| pix_mask | input | 8 | Bits the cursor may change |
| ld_en | input | 1 | Line-store write strobe |
| ld_addr | input | 9 | Line-store word address {line, plane, half} |
| ld_data | input | 32 | Line-store write data |
| pix_out | output | 8 | Blended output pixel |

## Verification
The assertions assume that frame_start is a clean single-cycle strobe. They also assume that the configuration inputs are steady across the two cycles a pixel spends in the pipeline, so that a masked or pass-through output can be traced back to the pixel two edges earlier. The stimulus follows these assumptions: it changes configuration and pulses frame_start only between isolated pixel probes, and it holds every probe's inputs for the full latency before sampling. Line-store loads are finished before any pixel that reads them is driven.

// File: rtl/curs_pkg.sv
package curs_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    CODE_BG  = 2'b00,
    CODE_FG  = 2'b01,
    CODE_SCR = 2'b10,
    CODE_INV = 2'b11
  } curs_code_e;
endpackage

// File: rtl/curs_linestore.sv
module curs_linestore import curs_pkg::*; #(
  parameter int LINES  = 128,
  parameter int HALVES = 2
) (
  input  logic                                      clk,
  input  logic                                      ld_en,
  input  logic [$clog2(LINES)+$clog2(2*HALVES)-1:0] ld_addr,
  input  logic [WORD_W-1:0]                         ld_data,
  input  logic [$clog2(LINES)-1:0]                  rd_line,
  output logic [2*HALVES*WORD_W-1:0]                rd_q
);
  localparam int BANKS = 2 * HALVES;
  localparam int BW    = $clog2(BANKS);
  localparam int LW    = $clog2(LINES);

  // one simple dual-port bank per {plane, half}
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [LINES];
    always_ff @(posedge clk) begin
      if (ld_en && (ld_addr[BW-1:0] == BW'(b)))
        mem[ld_addr[LW+BW-1:BW]] <= ld_data;
      rd_q[b*WORD_W +: WORD_W] <= mem[rd_line];
    end
  end
endmodule

// File: rtl/curs_blink.sv
module curs_blink #(
  parameter int FAST_BIT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic                blink_en,
  input  logic                blink_slow,
  output logic                vis,
  output logic [FAST_BIT+1:0] frame_cnt
);
  always_ff @(posedge clk) begin
    if (rst)              frame_cnt <= '0;
    else if (frame_start) frame_cnt <= frame_cnt + 1'b1;
  end

  logic phase_off;
  assign phase_off = blink_slow ? frame_cnt[FAST_BIT+1] : frame_cnt[FAST_BIT];
  assign vis       = !blink_en || !phase_off;
endmodule

// File: rtl/curs_hit.sv
module curs_hit #(
  parameter int XW   = 11,
  parameter int YW   = 11,
  parameter int HXW  = 6,
  parameter int HYW  = 7,
  parameter int MAXW = 64,
  parameter int MAXH = 128
) (
  input  logic [XW-1:0]            pix_x,
  input  logic [YW-1:0]            pix_y,
  input  logic [XW-1:0]            pos_x,
  input  logic [YW-1:0]            pos_y,
  input  logic [HXW-1:0]           hot_x,
  input  logic [HYW-1:0]           hot_y,
  input  logic                     wide,
  input  logic [1:0]               height,
  output logic                     hit,
  output logic [$clog2(MAXW)-1:0]  col,
  output logic [$clog2(MAXH)-1:0]  row
);
  localparam int CLW = $clog2(MAXW);
  localparam int LW  = $clog2(MAXH);
  localparam logic [XW+1:0] WFULL = MAXW[XW+1:0];
  localparam logic [YW+1:0] HFULL = MAXH[YW+1:0];

  logic [XW+1:0] cdiff, wlim;
  logic [YW+1:0] rdiff, hlim;

  always_comb begin
    cdiff = {2'b00, pix_x} - {2'b00, pos_x} + {{(XW+2-HXW){1'b0}}, hot_x};
    rdiff = {2'b00, pix_y} - {2'b00, pos_y} + {{(YW+2-HYW){1'b0}}, hot_y};
    wlim  = wide ? WFULL : (WFULL >> 1);
    hlim  = HFULL >> (2'd3 - height);
    hit   = !cdiff[XW+1] && (cdiff < wlim) && !rdiff[YW+1] && (rdiff < hlim);
    col   = cdiff[CLW-1:0];
    row   = rdiff[LW-1:0];
  end
endmodule

// File: rtl/curs_overlay.sv
module curs_overlay import curs_pkg::*; #(
  parameter int XW       = 11,
  parameter int YW       = 11,
  parameter int PW       = 8,
  parameter int MAXW     = 64,
  parameter int MAXH     = 128,
  parameter int HXW      = 6,
  parameter int HYW      = 7,
  parameter int FAST_BIT = 3
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           frame_start,
  input  logic [XW-1:0]                                  pix_x,
  input  logic [YW-1:0]                                  pix_y,
  input  logic [PW-1:0]                                  pix_in,
  input  logic                                           cur_en,
  input  logic [1:0]                                     cur_height,
  input  logic                                           cur_wide,
  input  logic                                           blink_en,
  input  logic                                           blink_slow,
  input  logic [XW-1:0]                                  pos_x,
  input  logic [YW-1:0]                                  pos_y,
  input  logic [HXW-1:0]                                 hot_x,
  input  logic [HYW-1:0]                                 hot_y,
  input  logic [PW-1:0]                                  color_fg,
  input  logic [PW-1:0]                                  color_bg,
  input  logic [PW-1:0]                                  pix_mask,
  input  logic                                           ld_en,
  input  logic [$clog2(MAXH)+$clog2(2*MAXW/32)-1:0]      ld_addr,
  input  logic [31:0]                                    ld_data,
  output logic [PW-1:0]                                  pix_out
);
  localparam int HALVES = MAXW / WORD_W;
  localparam int CLW    = $clog2(MAXW);
  localparam int LW     = $clog2(MAXH);
  localparam logic [CLW-1:0] LAST_WIDE   = CLW'(MAXW - 1);
  localparam logic [CLW-1:0] LAST_NARROW = CLW'(MAXW / 2 - 1);

  // stage 0: rectangle test and blink gate
  logic              hit, vis;
  logic [CLW-1:0]    col;
  logic [LW-1:0]     row;
  logic [FAST_BIT+1:0] frame_cnt;

  curs_hit #(.XW(XW), .YW(YW), .HXW(HXW), .HYW(HYW), .MAXW(MAXW), .MAXH(MAXH)) u_hit (
    .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
    .hot_x(hot_x), .hot_y(hot_y), .wide(cur_wide), .height(cur_height),
    .hit(hit), .col(col), .row(row)
  );

  curs_blink #(.FAST_BIT(FAST_BIT)) u_blink (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .blink_en(blink_en), .blink_slow(blink_slow),
    .vis(vis), .frame_cnt(frame_cnt)
  );

  logic [2*MAXW-1:0] line_q;

  curs_linestore #(.LINES(MAXH), .HALVES(HALVES)) u_store (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_line(row), .rd_q(line_q)
  );

  // stage 1: align pixel with the line-store read
  logic           s1_show, s1_wide;
  logic [CLW-1:0] s1_col;
  logic [PW-1:0]  s1_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_show <= 1'b0;
      s1_wide <= 1'b0;
      s1_col  <= '0;
      s1_pix  <= '0;
    end else begin
      s1_show <= cur_en && vis && hit;
      s1_wide <= cur_wide;
      s1_col  <= col;
      s1_pix  <= pix_in;
    end
  end

  // stage 2: code lookup, color select and masking
  logic [MAXW-1:0] map0, map1;
  logic [CLW-1:0]  bit_idx;
  curs_code_e      code;
  logic [PW-1:0]   cur_val, mixed;

  always_comb begin
    map0    = line_q[0 +: MAXW];
    map1    = line_q[MAXW +: MAXW];
    bit_idx = (s1_wide ? LAST_WIDE : LAST_NARROW) - s1_col;
    code    = curs_code_e'({map0[bit_idx], map1[bit_idx]});
    case (code)
      CODE_BG:  cur_val = color_bg;
      CODE_FG:  cur_val = color_fg;
      CODE_SCR: cur_val = s1_pix;
      default:  cur_val = ~s1_pix;
    endcase
    mixed = (s1_pix & ~pix_mask) | (cur_val & pix_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= s1_show ? mixed : s1_pix;
  end
endmodule

// File: rtl/curs_overlay_chk.sv
module curs_overlay_chk #(
  parameter int PW = 8,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          cur_en,
  input logic [PW-1:0] pix_in,
  input logic [PW-1:0] pix_mask,
  input logic [PW-1:0] pix_out,
  input logic          vis,
  input logic [CW-1:0] frame_cnt
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1: reset clears the output and the frame counter
  a_r1_reset_out: assert property (@(posedge clk) rst |=> (pix_out == '0 && frame_cnt == '0));

  // R9: disabled cursor leaves the pixel from two edges earlier untouched
  a_r9_disabled_pass: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(cur_en, 2)) |-> pix_out == $past(pix_in, 2));

  // R4: masked-off bits always follow the screen pixel
  a_r4_mask_keep: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> ((pix_out & ~$past(pix_mask, 1)) == ($past(pix_in, 2) & ~$past(pix_mask, 1))));

  // R10: hidden blink phase passes the screen pixel
  a_r10_blink_hidden: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(vis, 2)) |-> pix_out == $past(pix_in, 2));

  // R10: counter steps once per strobe and holds otherwise
  a_r10_cnt_step: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> frame_cnt == $past(frame_cnt) + 1'b1);
  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(frame_cnt));
endmodule

bind curs_overlay curs_overlay_chk #(.PW(PW), .CW(FAST_BIT + 2)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .cur_en(cur_en),
  .pix_in(pix_in), .pix_mask(pix_mask), .pix_out(pix_out),
  .vis(vis), .frame_cnt(frame_cnt)
);

// File: tb/sim_curs_overlay.sv
`timescale 1ns/1ps
module sim_curs_overlay;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [10:0] pix_x = '0, pix_y = '0, pos_x = '0, pos_y = '0;
  logic [7:0]  pix_in = '0, color_fg = '0, color_bg = '0, pix_mask = '0;
  logic        cur_en = 1'b0, cur_wide = 1'b0, blink_en = 1'b0, blink_slow = 1'b0;
  logic [1:0]  cur_height = '0;
  logic [5:0]  hot_x = '0;
  logic [6:0]  hot_y = '0;
  logic        ld_en = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [7:0]  pix_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  curs_overlay u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y),
    .pix_in(pix_in), .cur_en(cur_en), .cur_height(cur_height), .cur_wide(cur_wide),
    .blink_en(blink_en), .blink_slow(blink_slow), .pos_x(pos_x), .pos_y(pos_y),
    .hot_x(hot_x), .hot_y(hot_y), .color_fg(color_fg), .color_bg(color_bg),
    .pix_mask(pix_mask), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pix_out(pix_out)
  );

  localparam logic [7:0] SCR = 8'h71, FG = 8'hA5, BG = 8'h3C;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic load_line(input int line, input logic [63:0] m0, input logic [63:0] m1);
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = {line[6:0], p[0], h[0]};
        ld_data = (p == 0) ? m0[32*h +: 32] : m1[32*h +: 32];
      end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic probe(input int x, input int y, input logic [7:0] p, output logic [7:0] r);
    @(negedge clk);
    pix_x = x[10:0]; pix_y = y[10:0]; pix_in = p;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    r = pix_out;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
    end
  endtask

  task automatic base_cfg;
    @(negedge clk);
    cur_en = 1'b1; cur_wide = 1'b0; cur_height = 2'd0; blink_en = 1'b0; blink_slow = 1'b0;
    pos_x = 11'd100; pos_y = 11'd50; hot_x = '0; hot_y = '0;
    color_fg = FG; color_bg = BG; pix_mask = 8'hFF;
  endtask

  task automatic t_reset;
    check("R1 reset output", pix_out, 8'h00);
  endtask

  task automatic t_blink;
    logic [7:0] r;
    base_cfg(); blink_en = 1'b1;
    probe(101, 50, SCR, r); check("R10 frame 0 shown", r, FG);
    frames(8);
    probe(101, 50, SCR, r); check("R10 fast hidden at frame 8", r, SCR);
    blink_slow = 1'b1;
    probe(101, 50, SCR, r); check("R10 slow shown at frame 8", r, FG);
    frames(8);
    probe(101, 50, SCR, r); check("R10 slow hidden at frame 16", r, SCR);
    blink_slow = 1'b0;
    probe(101, 50, SCR, r); check("R10 fast shown at frame 16", r, FG);
    frames(8);
    blink_en = 1'b0;
    probe(101, 50, SCR, r); check("R10 blink off ignores counter", r, FG);
  endtask

  task automatic t_codes;
    logic [7:0] r;
    base_cfg();
    probe(100, 50, SCR, r); check("R3 code 00 background", r, BG);
    probe(101, 50, SCR, r); check("R3 code 01 foreground", r, FG);
    probe(102, 50, SCR, r); check("R3 code 10 screen", r, SCR);
    probe(103, 50, SCR, r); check("R3 code 11 invert", r, ~SCR);
    probe(103, 50, 8'h0F, r); check("R2 R3 invert second pixel", r, 8'hF0);
  endtask

  task automatic t_mask;
    logic [7:0] r;
    base_cfg(); pix_mask = 8'h0F;
    probe(101, 50, SCR, r); check("R4 low nibble masked", r, (SCR & 8'hF0) | (FG & 8'h0F));
    pix_mask = 8'h00;
    probe(101, 50, SCR, r); check("R4 zero mask passes", r, SCR);
  endtask

  task automatic t_width;
    logic [7:0] r;
    base_cfg();
    probe(100, 51, SCR, r); check("R8 narrow col0 bit31", r, BG);
    probe(108, 51, SCR, r); check("R8 narrow col8 bit23", r, FG);
    probe(140, 51, SCR, r); check("R6 narrow col40 outside", r, SCR);
    cur_wide = 1'b1;
    probe(100, 51, SCR, r); check("R8 wide col0 bit63", r, FG);
    probe(101, 51, SCR, r); check("R8 wide col1 bit62", r, BG);
    probe(140, 51, SCR, r); check("R6 wide col40 inside", r, FG);
    probe(164, 51, SCR, r); check("R6 wide col64 outside", r, SCR);
  endtask

  task automatic t_height;
    logic [7:0] r;
    base_cfg();
    probe(100, 65, SCR, r); check("R5 16 lines last row", r, FG);
    probe(100, 70, SCR, r); check("R5 16 lines row20 outside", r, SCR);
    cur_height = 2'd1;
    probe(100, 70, SCR, r); check("R5 32 lines row20 inside", r, FG);
    cur_height = 2'd2;
    probe(100, 177, SCR, r); check("R5 64 lines row127 outside", r, SCR);
    cur_height = 2'd3;
    probe(100, 177, SCR, r); check("R5 128 lines row127 inside", r, FG);
  endtask

  task automatic t_hotspot;
    logic [7:0] r;
    base_cfg(); hot_x = 6'd5; hot_y = 7'd3;
    probe(95, 47, SCR, r); check("R7 corner shifted by hot spot", r, BG);
    probe(94, 47, SCR, r); check("R7 left of corner", r, SCR);
    probe(95, 46, SCR, r); check("R7 above corner", r, SCR);
    pos_x = 11'd2; pos_y = 11'd1;
    probe(0, 0, SCR, r); check("R7 corner off screen col3 row2", r, ~SCR);
    probe(29, 0, SCR, r); check("R7 off screen col32 outside", r, SCR);
  endtask

  task automatic t_disable;
    logic [7:0] r;
    base_cfg(); cur_en = 1'b0;
    probe(101, 50, SCR, r); check("R9 disabled passes screen", r, SCR);
    cur_en = 1'b1;
    probe(300, 300, 8'h42, r); check("R9 outside passes screen", r, 8'h42);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    load_line(0,   64'h0000_0000_3000_0000, 64'h0000_0000_5000_0000);
    load_line(1,   64'h0, 64'h8000_0000_0080_0000);
    load_line(2,   64'h0000_0000_1000_0000, 64'h0000_0000_1000_0000);
    load_line(15,  64'h0, 64'h0000_0000_8000_0000);
    load_line(20,  64'h0, 64'h0000_0000_8000_0000);
    load_line(127, 64'h0, 64'h0000_0000_8000_0000);
    t_blink();
    t_codes();
    t_mask();
    t_width();
    t_height();
    t_hotspot();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule